// File: doc/BRIEF.md
# Fixed-Point DC Blocking Filter

This block removes the zero-frequency part of a signed sample stream. It is a first-order recursive high-pass section: the output is the current input minus the previous input, plus the previous output scaled by a pole coefficient R. That gives a zero at DC and a pole just inside it. When R is close to one the notch is narrow, and the filter settles to a new DC level in roughly 1/(1−R) samples.

Samples arrive with a valid strobe, and each accepted sample yields one output sample one clock later. R can be changed at run time. An optional normalisation multiplies the difference term by g = (1+R)/2, which holds the gain at half the sample rate to unity; without it that gain is 2/(1+R). The recursion keeps 8 fractional bits beyond the sample grid, and the output saturates instead of wrapping. At R = 1 the pole and zero cancel and the block passes its input through unchanged.

Top module: `dc_blocker`

## Requirements
- R1: While rst is high at a clock edge, out_valid and out_sample become 0, and the delayed input and delayed output state are cleared to zero.
- R2: With norm_en low, the full-precision state y, held with 8 fractional bits, is updated as y ← (x − x_prev)·2^8 + floor(y·R/2^15). The output is floor(y/2^8).
- R3: With norm_en high, the difference term becomes floor((x − x_prev)·g/2^7), where g = floor((32768 + R)/2) in unsigned Q1.15. The feedback term is the same as in R2.
- R4: coef_r is unsigned Q1.15, so 0x8000 means 1.0. Any value above 0x8000 acts exactly like 0x8000.
- R5: out_valid is high in the cycle after each cycle where in_valid is high, and low after each cycle where in_valid is low.
- R6: A cycle with in_valid low changes neither out_sample nor the filter state. The next accepted sample continues the recursion as if no gap had occurred.
- R7: out_sample saturates to +32767 or −32768 when floor(y/2^8) is outside the 16-bit signed range. The state y keeps its unsaturated value.
- R8: With R = 1.0 and norm_en low, starting from reset, every output equals the corresponding input exactly.
- R9: After a step of constant input A > 0, starting from reset with R = 0.995 (coef_r = 32604) and normalisation off, the output falls below A/100 within 5/(1−R) = 1000 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| coef_r | input | 16 | Pole coefficient, unsigned Q1.15 |
| norm_en | input | 1 | Enables the (1+R)/2 gain on the difference term |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed, saturated output sample |

## Verification
The hardest condition to reach is output saturation while the internal state stays above full scale. Only a signal near half the sample rate, at full-scale amplitude, with normalisation off and R close to one, drives the state there. The bench therefore feeds alternating +32767/−32768 samples with R = 0.998, first with normalisation off and then with it on. Every output is compared bit for bit with a reference model computed from the update equations. The bench also checks that saturated outputs really occurred, and that the recursion behind them stays exact.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int COEF_FRAC = 15;
  localparam int COEF_W    = 16;

  function automatic logic [COEF_W-1:0] clamp_coef(input logic [COEF_W-1:0] c);
    logic [COEF_W-1:0] one;
    one = COEF_W'(1) << COEF_FRAC;
    return (c > one) ? one : c;
  endfunction
endpackage

// File: rtl/dcb_diff.sv
module dcb_diff #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FB = 8,
  parameter int AW = 27
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic signed [DW-1:0] sample,
  input  logic [CW-1:0]        coef,
  input  logic                 norm_en,
  output logic signed [AW-1:0] term
);
  import dcb_pkg::*;
  localparam int PW = DW + CW + 2;
  localparam int SH = COEF_FRAC - FB;

  logic signed [DW-1:0] x_prev;
  logic signed [DW:0]   diff;
  logic [CW:0]          g_sum;
  logic [CW-1:0]        gain;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] prod_sh;
  logic signed [AW-1:0] term_raw;
  logic signed [AW-1:0] term_norm;

  always_ff @(posedge clk) begin
    if (rst)       x_prev <= '0;
    else if (load) x_prev <= sample;
  end

  always_comb begin
    diff      = {sample[DW-1], sample} - {x_prev[DW-1], x_prev};
    g_sum     = (CW+1)'(1) << COEF_FRAC;
    g_sum     = g_sum + {1'b0, coef};
    gain      = g_sum[CW:1];
    prod      = PW'(diff) * $signed({{(PW-CW){1'b0}}, gain});
    prod_sh   = prod >>> SH;
    term_norm = prod_sh[AW-1:0];
    term_raw  = $signed({{(AW-DW-1){diff[DW]}}, diff}) <<< FB;
    term      = norm_en ? term_norm : term_raw;
  end
endmodule

// File: rtl/dcb_pole.sv
module dcb_pole #(
  parameter int CW = 16,
  parameter int AW = 27
) (
  input  logic signed [AW-1:0] y_state,
  input  logic [CW-1:0]        coef,
  output logic signed [AW-1:0] fb
);
  import dcb_pkg::*;
  localparam int PW = AW + CW + 1;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] prod_sh;

  always_comb begin
    prod    = PW'(y_state) * $signed({{(PW-CW){1'b0}}, coef});
    prod_sh = prod >>> COEF_FRAC;
    fb      = prod_sh[AW-1:0];
  end
endmodule

// File: rtl/dcb_sat.sv
module dcb_sat #(
  parameter int DW = 16,
  parameter int FB = 8,
  parameter int AW = 27
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic signed [AW-1:0] y_full,
  output logic signed [DW-1:0] out_sample
);
  localparam int IW = AW - FB;
  localparam logic signed [IW-1:0] HI = {{(IW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [IW-1:0] LO = {{(IW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [AW-1:0] y_sh;
  logic signed [IW-1:0] y_int;
  logic signed [DW-1:0] y_clip;

  always_comb begin
    y_sh  = y_full >>> FB;
    y_int = y_sh[IW-1:0];
    if (y_int > HI)      y_clip = {1'b0, {(DW-1){1'b1}}};
    else if (y_int < LO) y_clip = {1'b1, {(DW-1){1'b0}}};
    else                 y_clip = y_int[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       out_sample <= '0;
    else if (load) out_sample <= y_clip;
  end

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (load && (y_int > HI)) |=> (out_sample == {1'b0, {(DW-1){1'b1}}})); // R7
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (load && (y_int < LO)) |=> (out_sample == {1'b1, {(DW-1){1'b0}}})); // R7
endmodule

// File: rtl/dc_blocker.sv
module dc_blocker #(
  parameter int DW = 16,
  parameter int FB = 8,
  parameter int GUARD = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  input  logic [15:0]   coef_r,
  input  logic          norm_en,
  output logic          out_valid,
  output logic [DW-1:0] out_sample
);
  import dcb_pkg::*;
  localparam int CW = COEF_W;
  localparam int AW = DW + GUARD + FB;

  logic [CW-1:0]        coef_eff;
  logic signed [AW-1:0] y_state;
  logic signed [AW-1:0] term;
  logic signed [AW-1:0] fb;
  logic signed [AW-1:0] y_next;
  logic signed [DW-1:0] sat_out;

  assign coef_eff = clamp_coef(coef_r);
  assign y_next   = term + fb;

  dcb_diff #(.DW(DW), .CW(CW), .FB(FB), .AW(AW)) u_diff (
    .clk(clk), .rst(rst), .load(in_valid), .sample($signed(in_sample)),
    .coef(coef_eff), .norm_en(norm_en), .term(term)
  );

  dcb_pole #(.CW(CW), .AW(AW)) u_pole (
    .y_state(y_state), .coef(coef_eff), .fb(fb)
  );

  dcb_sat #(.DW(DW), .FB(FB), .AW(AW)) u_sat (
    .clk(clk), .rst(rst), .load(in_valid), .y_full(y_next), .out_sample(sat_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      y_state   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) y_state <= y_next;
    end
  end

  assign out_sample = sat_out;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sample == '0)); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R5
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_sample) && $stable(y_state))); // R6
endmodule

// File: tb/tb_dc_blocker.sv
module tb_dc_blocker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic [15:0] coef_r = '0;
  logic        norm_en = 1'b0;
  logic        out_valid;
  logic [15:0] out_sample;

  int total = 0;
  int bad = 0;
  longint m_xp = 0;
  longint m_y = 0;
  longint m_out = 0;
  bit     m_sat = 0;

  always #2.5 clk = ~clk;

  dc_blocker dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .coef_r(coef_r), .norm_en(norm_en), .out_valid(out_valid), .out_sample(out_sample)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input longint x);
    longint r, g, d, t, yi;
    r = (coef_r > 16'h8000) ? 32768 : longint'(coef_r);
    g = (32768 + r) / 2;
    d = x - m_xp;
    t = norm_en ? ((d * g) >>> 7) : (d * 256);
    m_y = t + ((m_y * r) >>> 15);
    m_xp = x;
    yi = m_y >>> 8;
    m_sat = (yi > 32767) || (yi < -32768);
    m_out = (yi > 32767) ? 32767 : ((yi < -32768) ? -32768 : yi);
  endfunction

  task automatic push(input longint x, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 16'(x);
    model(x);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    check("R5", longint'(out_valid), 1);
    check(req, longint'($signed(out_sample)), m_out);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_xp = 0;
    m_y = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", longint'(out_valid), 0);
    check("R1", longint'($signed(out_sample)), 0);
    coef_r = 16'd29491;
    norm_en = 1'b0;
    push(1234, "R1");
  endtask

  task automatic t_step();
    do_reset();
    coef_r = 16'd32604;
    norm_en = 1'b0;
    for (int i = 0; i < 1000; i++) push(10000, "R2");
    total++;
    if ($signed(out_sample) >= 100 || $signed(out_sample) < 0) begin
      bad++;
      $display("FAIL R9 actual=%0d expected=<100", $signed(out_sample));
    end
  endtask

  task automatic t_impulse();
    do_reset();
    coef_r = 16'd29491;
    norm_en = 1'b1;
    push(20000, "R3");
    for (int i = 0; i < 63; i++) push(0, "R3");
    norm_en = 1'b0;
    do_reset();
    push(-20000, "R2");
    for (int i = 0; i < 63; i++) push(0, "R2");
  endtask

  task automatic t_alternate();
    int sat_seen;
    do_reset();
    coef_r = 16'd32702;
    norm_en = 1'b0;
    sat_seen = 0;
    for (int i = 0; i < 400; i++) begin
      push((i % 2 == 0) ? 32767 : -32768, "R7");
      if (m_sat) sat_seen++;
    end
    check("R7", longint'(sat_seen > 0), 1);
    do_reset();
    norm_en = 1'b1;
    for (int i = 0; i < 400; i++) push((i % 2 == 0) ? 32767 : -32768, "R3");
  endtask

  task automatic t_gap();
    logic [15:0] held;
    do_reset();
    coef_r = 16'd31000;
    norm_en = 1'b0;
    push(5000, "R2");
    push(-3000, "R2");
    held = out_sample;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_sample = 16'h7FFF;
      check("R5", longint'(out_valid), (i == 0) ? 1 : 0);
      if (i > 0) check("R6", longint'(out_sample), longint'(held));
    end
    push(7000, "R6");
    push(7000, "R6");
  endtask

  task automatic t_unity(input logic [15:0] c, input string req);
    int unsigned lcg;
    longint x;
    do_reset();
    coef_r = c;
    norm_en = 1'b0;
    lcg = 32'd12345;
    for (int i = 0; i < 200; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      x = longint'($signed(lcg[31:16]));
      push(x, req);
      check("R8", longint'($signed(out_sample)), x);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_step();
    t_impulse();
    t_alternate();
    t_gap();
    t_unity(16'h8000, "R8");
    t_unity(16'hFFFF, "R4");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule